// File: doc/BRIEF.md
# Random-Bit Generator Alarm and Interrupt Controller

This block gathers the event pulses that a random-bit generator and its online health tests produce: a data-ready pulse, a repeated-block failure, a run-length failure, and the start, pass and fail pulses of an autocorrelation test that lives outside the block. Each event is latched into a status register. A per-bit mask selects which latched events may drive a single level interrupt line. Software clears the ordinary events by writing ones to a clear register.

A run of consecutive autocorrelation failures is fatal. When it occurs, the block latches an error that software cannot clear, and it raises a halt output that stops the generator until a hardware reset or a software reset write. A pair of saturating counters records how many autocorrelation tests started and how many failed. Any write to their register zeroes both counters.

Register access is through a simple word-addressed write port and a read port with a one-cycle registered read.

Top module: `rac_alarm_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the mask, status and statistics registers read 0, `irq_o` is 0 and `halted_o` is 0.
- R2: Word addresses are 0 mask, 1 status, 2 clear, 3 statistics, 4 software reset. `bus_rdata_o` shows the register selected by `bus_addr_i` one clock later. The clear and software-reset addresses read 0. A pulse on `evt_valid_i`, `evt_rep_i` or `evt_run_i` sets status bit 0, 2 or 3 respectively, and status bits 31:4 read 0.
- R3: `irq_o` is 1 exactly when some status bit is 1 and the mask bit at the same position (bits 3:0) is 0.
- R4: Writing ones to bits 0, 2 or 3 of the clear register clears the matching status bits.
- R5: Writing to bit 1 of the clear register leaves status bit 1 (autocorrelation error) unchanged.
- R6: When an event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R7: Status bit 1 sets after FAIL_RUN consecutive pulses on `ac_fail_i` (4 by default). A pulse on `ac_pass_i` resets the consecutive-failure run to zero.
- R8: While status bit 1 is set, `halted_o` is 1. In that state, `evt_valid_i`, `ac_start_i` and `ac_fail_i` have no effect on status or statistics.
- R9: The statistics register holds the start count in bits START_W-1:0 (13:0 by default) and the failure count in the next FAIL_W bits (21:14 by default). Each `ac_start_i` pulse and each `ac_fail_i` pulse adds one to its counter.
- R10: Any write to the statistics address clears both counters.
- R11: Once either counter holds its all-ones maximum, neither counter changes on further start or fail pulses.
- R12: Writing 1 to bit 0 of the software-reset address clears the status (including bit 1), the failure run and both counters, and releases the halt. The mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid_i | input | 1 | Data-ready event pulse |
| evt_rep_i | input | 1 | Repeated-block failure pulse |
| evt_run_i | input | 1 | Run-length failure pulse |
| ac_start_i | input | 1 | Autocorrelation test start pulse |
| ac_pass_i | input | 1 | Autocorrelation test pass pulse |
| ac_fail_i | input | 1 | Autocorrelation test fail pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| halted_o | output | 1 | Generator halt |

## Verification
The bench builds the block with START_W = 4, FAIL_W = 4 and FAIL_RUN = 4. The narrow counters let both saturation limits be reached within a few dozen pulses. The start counter freezes first in one scenario, and the failure counter freezes first in another. Pass pulses are interleaved with the failures so that the fatal error does not trip. The packed field position of the failure count changes with these widths, so the placement rule is checked at a width other than the default.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_EVT  = 4;
  localparam int ADDR_W   = 3;

  // status / mask / clear bit positions
  localparam int EVT_VALID = 0;
  localparam int EVT_AC    = 1;
  localparam int EVT_REP   = 2;
  localparam int EVT_RUN   = 3;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SWRST = 3'd4;
endpackage

// File: rtl/rac_status_bit.sv
module rac_status_bit #(
  parameter bit STICKY = 1'b0
) (
  input  logic clk,
  input  logic clr_all_i,
  input  logic set_i,
  input  logic wclr_i,
  output logic q_o
);
  logic q;

  // set beats a software clear; sticky bits ignore the clear entirely
  always_ff @(posedge clk) begin
    if (clr_all_i)                 q <= 1'b0;
    else if (set_i)                q <= 1'b1;
    else if (wclr_i && !STICKY)    q <= 1'b0;
  end

  assign q_o = q;
endmodule

// File: rtl/rac_ac_monitor.sv
module rac_ac_monitor #(
  parameter int FAIL_RUN = 4
) (
  input  logic clk,
  input  logic clr_all_i,
  input  logic halted_i,
  input  logic fail_i,
  input  logic pass_i,
  output logic trip_o
);
  localparam int RW = (FAIL_RUN < 2) ? 1 : $clog2(FAIL_RUN);
  localparam logic [RW-1:0] LAST = RW'(FAIL_RUN - 1);

  logic [RW-1:0] run_q;

  assign trip_o = fail_i && !halted_i && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (clr_all_i) begin
      run_q <= '0;
    end else if (!halted_i) begin
      if (fail_i)      run_q <= trip_o ? '0 : run_q + 1'b1;
      else if (pass_i) run_q <= '0;
    end
  end
endmodule

// File: rtl/rac_stats.sv
module rac_stats #(
  parameter int START_W = 14,
  parameter int FAIL_W  = 8
) (
  input  logic               clk,
  input  logic               clr_all_i,
  input  logic               wr_clr_i,
  input  logic               start_i,
  input  logic               fail_i,
  output logic [START_W-1:0] starts_o,
  output logic [FAIL_W-1:0]  fails_o
);
  logic [START_W-1:0] starts_q;
  logic [FAIL_W-1:0]  fails_q;
  logic               frozen;

  assign frozen = (&starts_q) || (&fails_q);

  always_ff @(posedge clk) begin
    if (clr_all_i || wr_clr_i) begin
      starts_q <= '0;
      fails_q  <= '0;
    end else if (!frozen) begin
      if (start_i) starts_q <= starts_q + 1'b1;
      if (fail_i)  fails_q  <= fails_q + 1'b1;
    end
  end

  assign starts_o = starts_q;
  assign fails_o  = fails_q;
endmodule

// File: rtl/rac_alarm_ctrl.sv
module rac_alarm_ctrl
  import rac_pkg::*;
#(
  parameter int FAIL_RUN = 4,
  parameter int START_W  = 14,
  parameter int FAIL_W   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        evt_valid_i,
  input  logic        evt_rep_i,
  input  logic        evt_run_i,
  input  logic        ac_start_i,
  input  logic        ac_pass_i,
  input  logic        ac_fail_i,
  input  logic        bus_wr_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o,
  output logic        halted_o
);
  localparam int CNT_W = START_W + FAIL_W;

  logic wr_mask, wr_clr, wr_cnt, wr_swrst, clr_all;
  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] status_q;
  logic [NUM_EVT-1:0] set_vec;
  logic [NUM_EVT-1:0] clr_vec;
  logic               halted;
  logic               trip;
  logic [START_W-1:0] st_starts;
  logic [FAIL_W-1:0]  st_fails;
  logic [REG_W-1:0]   rd_next;

  assign wr_mask  = bus_wr_i && (bus_addr_i == A_MASK);
  assign wr_clr   = bus_wr_i && (bus_addr_i == A_CLR);
  assign wr_cnt   = bus_wr_i && (bus_addr_i == A_CNT);
  assign wr_swrst = bus_wr_i && (bus_addr_i == A_SWRST) && bus_wdata_i[0];
  assign clr_all  = rst || wr_swrst;

  assign halted = status_q[EVT_AC];

  // mask survives the software reset
  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata_i[NUM_EVT-1:0];
  end

  rac_ac_monitor #(.FAIL_RUN(FAIL_RUN)) u_acmon (
    .clk       (clk),
    .clr_all_i (clr_all),
    .halted_i  (halted),
    .fail_i    (ac_fail_i),
    .pass_i    (ac_pass_i),
    .trip_o    (trip)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[EVT_VALID] = evt_valid_i && !halted;
    set_vec[EVT_AC]    = trip;
    set_vec[EVT_REP]   = evt_rep_i;
    set_vec[EVT_RUN]   = evt_run_i;
    clr_vec            = wr_clr ? bus_wdata_i[NUM_EVT-1:0] : '0;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
    rac_status_bit #(.STICKY(i == EVT_AC)) u_bit (
      .clk       (clk),
      .clr_all_i (clr_all),
      .set_i     (set_vec[i]),
      .wclr_i    (clr_vec[i]),
      .q_o       (status_q[i])
    );
  end

  rac_stats #(.START_W(START_W), .FAIL_W(FAIL_W)) u_stats (
    .clk       (clk),
    .clr_all_i (clr_all),
    .wr_clr_i  (wr_cnt),
    .start_i   (ac_start_i && !halted),
    .fail_i    (ac_fail_i && !halted),
    .starts_o  (st_starts),
    .fails_o   (st_fails)
  );

  always_comb begin
    rd_next = '0;
    case (bus_addr_i)
      A_MASK:  rd_next[NUM_EVT-1:0] = mask_q;
      A_STAT:  rd_next[NUM_EVT-1:0] = status_q;
      A_CNT:   rd_next[CNT_W-1:0]   = {st_fails, st_starts};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_o <= '0;
    else     bus_rdata_o <= rd_next;
  end

  assign irq_o    = |(status_q & ~mask_q);
  assign halted_o = halted;
endmodule

// File: rtl/rac_alarm_chk.sv
module rac_alarm_chk
  import rac_pkg::*;
#(
  parameter int START_W = 14,
  parameter int FAIL_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr_i,
  input logic [2:0]         bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic               evt_valid_i,
  input logic               evt_rep_i,
  input logic [3:0]         status_q,
  input logic [START_W-1:0] st_starts,
  input logic [FAIL_W-1:0]  st_fails
);
  logic swrst, cnt_wr;
  assign swrst  = bus_wr_i && (bus_addr_i == A_SWRST) && bus_wdata_i[0];
  assign cnt_wr = bus_wr_i && (bus_addr_i == A_CNT);

  assert_ac_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (status_q[1] && !swrst) |=> status_q[1]);

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == A_CLR && bus_wdata_i[0] && !evt_valid_i) |=> !status_q[0]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_rep_i && !swrst) |=> status_q[2]);

  assert_halt_blocks_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (status_q[1] && !status_q[0] && !swrst) |=> !status_q[0]);

  assert_sat_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    (((&st_starts) || (&st_fails)) && !cnt_wr && !swrst) |=> ($stable(st_starts) && $stable(st_fails)));

  assert_swrst_clears_R12: assert property (@(posedge clk) disable iff (rst)
    swrst |=> (status_q == 4'd0));
endmodule

bind rac_alarm_ctrl rac_alarm_chk #(.START_W(START_W), .FAIL_W(FAIL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .evt_valid_i (evt_valid_i),
  .evt_rep_i   (evt_rep_i),
  .status_q    (status_q),
  .st_starts   (st_starts),
  .st_fails    (st_fails)
);

// File: tb/rac_alarm_ctrl_bench.sv
`timescale 1ns/1ps
module rac_alarm_ctrl_bench;
  localparam int ST_W = 4;
  localparam int FL_W = 4;
  localparam int RUN  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid_i = 0, evt_rep_i = 0, evt_run_i = 0;
  logic        ac_start_i = 0, ac_pass_i = 0, ac_fail_i = 0;
  logic        bus_wr_i = 0;
  logic [2:0]  bus_addr_i = 0;
  logic [31:0] bus_wdata_i = 0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, halted_o;

  always #5 clk = ~clk;

  rac_alarm_ctrl #(.FAIL_RUN(RUN), .START_W(ST_W), .FAIL_W(FL_W)) u_rac_alarm_ctrl (
    .clk(clk), .rst(rst),
    .evt_valid_i(evt_valid_i), .evt_rep_i(evt_rep_i), .evt_run_i(evt_run_i),
    .ac_start_i(ac_start_i), .ac_pass_i(ac_pass_i), .ac_fail_i(ac_fail_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .halted_o(halted_o)
  );

  // scoreboard: sel 0 = read data, 1 = irq, 2 = halted
  int          sel_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) begin
    #1;
    while (sel_q.size() > 0) begin
      int          s;
      logic [31:0] e, a;
      string       t;
      s = sel_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      a = (s == 0) ? bus_rdata_o : (s == 1) ? {31'd0, irq_o} : {31'd0, halted_o};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  function automatic logic [31:0] cnt(input int s, input int f);
    return (32'(f) << ST_W) | 32'(s);
  endfunction

  task automatic idle();
    evt_valid_i = 0; evt_rep_i = 0; evt_run_i = 0;
    ac_start_i = 0; ac_pass_i = 0; ac_fail_i = 0;
    bus_wr_i = 0; bus_wdata_i = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk); idle();
  endtask

  // 0 valid,1 rep,2 run,3 start,4 pass,5 fail,6 start+fail,7 start+pass
  task automatic pulse(input int w);
    @(negedge clk);
    case (w)
      0: evt_valid_i = 1;
      1: evt_rep_i = 1;
      2: evt_run_i = 1;
      3: ac_start_i = 1;
      4: ac_pass_i = 1;
      5: ac_fail_i = 1;
      6: begin ac_start_i = 1; ac_fail_i = 1; end
      default: begin ac_start_i = 1; ac_pass_i = 1; end
    endcase
    @(negedge clk); idle();
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_addr_i = a;
    sel_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #2;
  endtask

  task automatic chk_pin(input int s, input logic e, input string t);
    @(negedge clk);
    sel_q.push_back(s); exp_q.push_back({31'd0, e}); tag_q.push_back(t);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_rd(3'd0, 0, "R1 mask");
    chk_rd(3'd1, 0, "R1 status");
    chk_rd(3'd3, 0, "R1 stats");
    chk_pin(1, 0, "R1 irq");
    chk_pin(2, 0, "R1 halted");
    // R2 event latching, R3 interrupt
    pulse(0);
    chk_rd(3'd1, 32'h1, "R2 valid bit0");
    chk_pin(1, 1, "R3 irq unmasked");
    wr(3'd0, 32'h1);
    chk_pin(1, 0, "R3 irq masked");
    pulse(1);
    pulse(2);
    chk_rd(3'd1, 32'hD, "R2 rep bit2 run bit3");
    chk_pin(1, 1, "R3 irq from rep/run");
    chk_rd(3'd2, 0, "R2 clear addr reads 0");
    // R4 write-one-to-clear
    wr(3'd2, 32'h4);
    chk_rd(3'd1, 32'h9, "R4 clear bit2 only");
    wr(3'd2, 32'hFFFF_FFFD);
    chk_rd(3'd1, 32'h0, "R4 clear all");
    chk_pin(1, 0, "R3 irq idle");
    // R6 set wins
    @(negedge clk);
    evt_run_i = 1; bus_wr_i = 1; bus_addr_i = 3'd2; bus_wdata_i = 32'h8;
    @(negedge clk); idle();
    chk_rd(3'd1, 32'h8, "R6 set beats clear");
    wr(3'd2, 32'h8);
    // R7 run of failures; pass restarts the run
    for (int i = 0; i < RUN - 1; i++) pulse(6);
    pulse(7);
    for (int i = 0; i < RUN - 1; i++) pulse(6);
    chk_rd(3'd1, 32'h0, "R7 pass resets run");
    chk_rd(3'd3, cnt(2*RUN - 1, 2*RUN - 2), "R9 stats count");
    pulse(6);
    chk_rd(3'd1, 32'h2, "R7 ac error set");
    chk_pin(2, 1, "R8 halted");
    chk_pin(1, 1, "R3 irq from ac error");
    chk_rd(3'd3, cnt(2*RUN, 2*RUN - 1), "R9 stats packed");
    // R5 cannot clear bit1
    wr(3'd2, 32'h2);
    chk_rd(3'd1, 32'h2, "R5 ac error sticky");
    // R8 inputs ignored while halted
    pulse(0);
    pulse(6);
    chk_rd(3'd1, 32'h2, "R8 valid ignored");
    chk_rd(3'd3, cnt(2*RUN, 2*RUN - 1), "R8 stats frozen by halt");
    // R12 software reset
    wr(3'd4, 32'h0);
    chk_pin(2, 1, "R12 write 0 no reset");
    wr(3'd4, 32'h1);
    chk_rd(3'd1, 32'h0, "R12 status cleared");
    chk_pin(2, 0, "R12 halt released");
    chk_rd(3'd3, 0, "R12 stats cleared");
    chk_rd(3'd0, 32'h1, "R12 mask kept");
    // R10 any write clears stats
    pulse(6); pulse(7); pulse(3);
    chk_rd(3'd3, cnt(3, 1), "R9 counts after reset");
    wr(3'd3, 32'h0);
    chk_rd(3'd3, 0, "R10 stats write clears");
    // R11 start counter saturates
    for (int i = 0; i < (1 << ST_W) - 1; i++) pulse(7);
    pulse(6);
    chk_rd(3'd3, cnt((1 << ST_W) - 1, 0), "R11 start sat freezes both");
    wr(3'd3, 32'hABCD);
    // R11 fail counter saturates (passes avoid trip)
    for (int i = 0; i < (1 << FL_W) - 1; i++) begin pulse(5); pulse(4); end
    pulse(3);
    pulse(5);
    chk_rd(3'd3, cnt(0, (1 << FL_W) - 1), "R11 fail sat freezes both");
    chk_rd(3'd1, 32'h0, "R7 no trip with passes");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule